// File: doc/BRIEF.md
# Low-Transition Test Pattern Generator

This block feeds the primary inputs of a circuit under test during built-in self-test. Its core is a 36-bit maximal-length Fibonacci LFSR. The circuit under test does not see the raw LFSR sequence. Between any two successive LFSR states it sees three blended vectors. Each bit of a blended vector comes either from the register's present state or from its next state. The bits switch over from present to next one group at a time, so every output bit changes at most once on the way from one LFSR state to the next. The total switching on the pattern bus across those steps therefore equals the Hamming distance between the two states, spread over four clock cycles instead of one.

The register is split into four equal groups of 9 bits. A 2-bit phase counter chooses how many groups already show the next state, and a per-bit 2:1 multiplexer forms the vector. The LFSR advances only on the step that leaves the last blended vector. The pattern bus is registered. A valid strobe marks every cycle in which a new vector was produced.

A seed can be loaded at any time. An all-zero seed is replaced by a fixed nonzero default, so the register cannot lock up.

Top module: `lt_pattern_gen`

## Requirements
- R1: After reset, `pattern_o` is all zeros and `valid_o` is low. The register holds the default seed 36'h95A5A5A5A and the phase is 0.
- R2: A cycle with `seed_load` high loads `seed` into the register and restarts the phase at 0. The next vector emitted afterwards equals the loaded seed.
- R3: If `seed_load` is high while `seed` is all zeros, the register receives the default seed 36'h95A5A5A5A. The register never holds zero.
- R4: The register follows x^36 + x^25 + 1. Its next state is `{s[34:0], s[35]^s[24]}`. The vector emitted at phase 0 is always the present LFSR state.
- R5: Group g is bits [9g+8:9g]. At phase k (k = 1, 2, 3), the emitted vector takes groups 0 to k-1 from the next state and the remaining groups from the present state.
- R6: Across the five vectors T1, Ta, Tb, Tc, T2, each bit toggles at most once. The sum of the step-by-step Hamming distances equals the Hamming distance between T1 and T2.
- R7: With `en` low and `seed_load` low, `pattern_o` holds its value, `valid_o` is low, and the register and phase do not change.
- R8: `valid_o` is high in the cycle after each clock edge at which `en` was high and `seed_load` was low, and low otherwise. The phase then advances modulo 4.
- R9: When `seed_load` and `en` are high together, the load takes effect and no vector is emitted: `pattern_o` holds and `valid_o` is low.
- R10: The LFSR advances only at an enabled edge at phase 3. It stays unchanged during phases 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Produce one vector this cycle |
| seed_load | input | 1 | Load `seed` into the register and restart the phase |
| seed | input | 36 | Seed value (zero is replaced by the default) |
| pattern_o | output | 36 | Registered test pattern |
| valid_o | output | 1 | High when `pattern_o` holds a newly produced vector |

## Verification
A seed load can land in the same cycle as the LFSR advance that ends a run, that is, with `en` high at phase 3. The load must win: the advance is dropped and the new seed becomes the next T1. The bench provokes this by driving `seed_load` together with `en` exactly when its model is at phase 3. It also loads a zero seed with `en` low and loads in the middle of a run. The scoreboard then expects a held, non-valid output for that cycle and the loaded or default seed as the next phase-0 vector. Independently of the model, every complete five-vector run seen on the pattern bus is checked for single toggles per bit and for matching Hamming totals.

// File: rtl/ltpg_pkg.sv
package ltpg_pkg;
  // Default geometry of the generator
  localparam int unsigned LTPG_WIDTH  = 36;
  localparam int unsigned LTPG_GROUPS = 4;
  // Tap mask for x^36 + x^25 + 1 (bit 35 and bit 24)
  localparam logic [LTPG_WIDTH-1:0] LTPG_TAPS = 36'h801000000;
  // Replacement for an all-zero seed and reset value
  localparam logic [LTPG_WIDTH-1:0] LTPG_SEED = 36'h95A5A5A5A;
endpackage

// File: rtl/ltpg_lfsr.sv
module ltpg_lfsr #(
  parameter int unsigned     WIDTH        = ltpg_pkg::LTPG_WIDTH,
  parameter logic [WIDTH-1:0] TAPS         = ltpg_pkg::LTPG_TAPS,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = ltpg_pkg::LTPG_SEED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             advance,
  output logic [WIDTH-1:0] state_o,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] seed_fixed;
  logic             feedback;

  // First level: present and next state side by side
  assign feedback   = ^(state_q & TAPS);
  assign next_o     = {state_q[WIDTH-2:0], feedback};
  assign state_o    = state_q;
  assign seed_fixed = (seed == '0) ? DEFAULT_SEED : seed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DEFAULT_SEED;
    end else if (load) begin
      state_q <= seed_fixed;
    end else if (advance) begin
      state_q <= next_o;
    end
  end

  p_never_zero_r3: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  p_zero_seed_r3: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> state_q == DEFAULT_SEED);
  p_seed_taken_r2: assert property (@(posedge clk) disable iff (rst)
    (load && seed != '0) |=> state_q == $past(seed));
  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && advance) |=> state_q == $past(next_o));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(state_q));
endmodule

// File: rtl/ltpg_phase.sv
module ltpg_phase #(
  parameter int unsigned STEPS = ltpg_pkg::LTPG_GROUPS,
  localparam int unsigned PW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          step,
  output logic [PW-1:0] phase_o,
  output logic          last_o
);
  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  logic [PW-1:0] phase_q;

  assign phase_o = phase_q;
  assign last_o  = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (step) begin
      phase_q <= last_o ? '0 : phase_q + 1'b1;
    end
  end

  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> phase_q == '0);
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!restart && !step) |=> $stable(phase_q));
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!restart && step && last_o) |=> phase_q == '0);
endmodule

// File: rtl/ltpg_mixer.sv
module ltpg_mixer #(
  parameter int unsigned WIDTH  = ltpg_pkg::LTPG_WIDTH,
  parameter int unsigned GROUPS = ltpg_pkg::LTPG_GROUPS,
  localparam int unsigned PW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int unsigned GW    = WIDTH / GROUPS
) (
  input  logic [WIDTH-1:0] present_i,
  input  logic [WIDTH-1:0] next_i,
  input  logic [PW-1:0]    phase_i,
  output logic [WIDTH-1:0] mixed_o
);
  // Second level: one 2:1 select per group, shared by its bits
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int unsigned LO = g * GW;
    localparam int unsigned HI = (g == GROUPS - 1) ? WIDTH - 1 : LO + GW - 1;
    logic take_next;
    assign take_next = (int'(phase_i) > g);
    assign mixed_o[HI:LO] = take_next ? next_i[HI:LO] : present_i[HI:LO];
  end
endmodule

// File: rtl/lt_pattern_gen.sv
module lt_pattern_gen #(
  parameter int unsigned      WIDTH        = ltpg_pkg::LTPG_WIDTH,
  parameter int unsigned      GROUPS       = ltpg_pkg::LTPG_GROUPS,
  parameter logic [WIDTH-1:0] TAPS         = ltpg_pkg::LTPG_TAPS,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = ltpg_pkg::LTPG_SEED
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] pattern_o,
  output logic             valid_o
);
  localparam int unsigned PW = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic             step;
  logic             advance;
  logic             last_phase;
  logic [PW-1:0]    phase;
  logic [WIDTH-1:0] present;
  logic [WIDTH-1:0] next;
  logic [WIDTH-1:0] mixed;

  // A load always wins over an emission or an advance
  assign step    = en && !seed_load;
  assign advance = step && last_phase;

  ltpg_lfsr #(.WIDTH(WIDTH), .TAPS(TAPS), .DEFAULT_SEED(DEFAULT_SEED)) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .load    (seed_load),
    .seed    (seed),
    .advance (advance),
    .state_o (present),
    .next_o  (next)
  );

  ltpg_phase #(.STEPS(GROUPS)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .restart (seed_load),
    .step    (step),
    .phase_o (phase),
    .last_o  (last_phase)
  );

  ltpg_mixer #(.WIDTH(WIDTH), .GROUPS(GROUPS)) u_mixer (
    .present_i (present),
    .next_i    (next),
    .phase_i   (phase),
    .mixed_o   (mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pattern_o <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= step;
      if (step) begin
        pattern_o <= mixed;
      end
    end
  end

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!en && !seed_load) |=> ($stable(pattern_o) && !valid_o));
  p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> ($stable(pattern_o) && !valid_o));
  p_base_is_state_r4: assert property (@(posedge clk) disable iff (rst)
    (step && phase == '0) |=> pattern_o == $past(present));
  p_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    step |=> valid_o);
endmodule

// File: tb/lt_pattern_gen_test.sv
`timescale 1ns/1ps
module lt_pattern_gen_test;
  localparam logic [35:0] DEF = 36'h95A5A5A5A;

  typedef struct {
    logic [35:0] pat;
    logic        vld;
    int          ph;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        seed_load = 1'b0;
  logic [35:0] seed = '0;
  logic [35:0] pattern_o;
  logic        valid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  item_t q[$];

  // Reference model state
  logic [35:0] m_state = DEF;
  logic [35:0] m_pat   = '0;
  int          m_phase = 0;
  bit          m_after_load = 1'b0;
  string       m_load_req = "R2";

  // Run window for R6
  logic [35:0] run_buf[5];
  int          run_n = 0;

  always #10 clk = ~clk;

  lt_pattern_gen uut (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load), .seed(seed),
    .pattern_o(pattern_o), .valid_o(valid_o)
  );

  function automatic logic [35:0] ref_next(logic [35:0] s);
    return {s[34:0], s[35] ^ s[24]};
  endfunction

  function automatic logic [35:0] ref_mix(logic [35:0] p, logic [35:0] n, int ph);
    logic [35:0] r;
    for (int b = 0; b < 36; b++) r[b] = ((b / 9) < ph) ? n[b] : p[b];
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [35:0] act, logic [35:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit e, bit l, logic [35:0] s);
    item_t it;
    logic [35:0] nx;
    @(negedge clk);
    en = e; seed_load = l; seed = s;
    it.ph = -1;
    if (l) begin
      m_state = (s == '0) ? DEF : s;
      m_phase = 0;
      m_after_load = 1'b1;
      m_load_req = (s == '0) ? "R3" : (e ? "R2,R9" : "R2");
      it.vld = 1'b0;
      it.req = e ? "R9" : "R2";
    end else if (e) begin
      nx = ref_next(m_state);
      m_pat = ref_mix(m_state, nx, m_phase);
      it.vld = 1'b1;
      it.ph = m_phase;
      if (m_phase == 0) begin
        it.req = m_after_load ? m_load_req : "R4";
        m_after_load = 1'b0;
      end else begin
        it.req = "R5,R10";
      end
      if (m_phase == 3) m_state = nx;
      m_phase = (m_phase + 1) % 4;
    end else begin
      it.vld = 1'b0;
      it.req = "R7";
    end
    it.pat = m_pat;
    q.push_back(it);
  endtask

  task automatic check_run();
    int sum_steps = 0;
    bit once_ok = 1'b1;
    for (int b = 0; b < 36; b++) begin
      int flips = 0;
      for (int k = 0; k < 4; k++) flips += (run_buf[k][b] != run_buf[k+1][b]) ? 1 : 0;
      if (flips > 1) once_ok = 1'b0;
    end
    for (int k = 0; k < 4; k++) sum_steps += $countones(run_buf[k] ^ run_buf[k+1]);
    check(once_ok, "R6", "bit toggled twice in run", run_buf[0], run_buf[4]);
    check(sum_steps == $countones(run_buf[0] ^ run_buf[4]), "R6", "transition total",
          36'(sum_steps), 36'($countones(run_buf[0] ^ run_buf[4])));
  endtask

  // Monitor / scoreboard
  always begin
    item_t it;
    @(posedge clk);
    #5;
    if (q.size() > 0) begin
      it = q.pop_front();
      check(valid_o === it.vld, it.vld ? "R8" : it.req, "valid", {35'b0, valid_o}, {35'b0, it.vld});
      check(pattern_o === it.pat, it.req, "pattern", pattern_o, it.pat);
      if (it.req == "R9" || it.req == "R2") run_n = 0;
      if (it.vld) begin
        if (it.ph == 0) begin
          if (run_n == 4) begin
            run_buf[4] = pattern_o;
            check_run();
          end
          run_buf[0] = pattern_o;
          run_n = 1;
        end else if (run_n > 0 && run_n < 4) begin
          run_buf[run_n] = pattern_o;
          run_n++;
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #5;
    // R1: reset state at the ports
    check(pattern_o === '0, "R1", "reset pattern", pattern_o, '0);
    check(valid_o === 1'b0, "R1", "reset valid", {35'b0, valid_o}, '0);
    // R1 default seed is the first emitted vector
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b0, '0);
    // R7/R8: sparse enables
    for (int i = 0; i < 45; i++) drive(i % 3 != 0, 1'b0, '0);
    // R9 + R10: load on the advance cycle
    while (m_phase != 3) drive(1'b1, 1'b0, '0);
    drive(1'b1, 1'b1, 36'h123456789);
    for (int i = 0; i < 21; i++) drive(1'b1, 1'b0, '0);
    // R3: zero seed while idle
    drive(1'b0, 1'b1, '0);
    drive(1'b0, 1'b0, '0);
    for (int i = 0; i < 21; i++) drive(1'b1, 1'b0, '0);
    // R2: load mid-run with en low
    while (m_phase != 2) drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b1, 36'h800000001);
    for (int i = 0; i < 30; i++) drive(i % 5 != 4, 1'b0, '0);
    // Long run for R4/R5/R6
    for (int i = 0; i < 3000; i++) drive(1'b1, 1'b0, '0);
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, '0);
    repeat (3) @(posedge clk);
    #6;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule